// File: doc/BRIEF.md
# Dual-Issue Microcode Fetch Sequencer

This block steers a small vector coprocessor. The coprocessor fetches one 64-bit instruction pair per step. Each pair has an upper word and a lower word. The sequencer owns the program counter, a byte address that advances by 8 per pair. It decodes the control flags in the upper word, and from them it handles:

- a stop that takes effect one pair late;
- a branch that takes effect one pair late;
- debug and trap interrupt requests, each gated by an enable;
- an immediate mode, in which the lower word is captured as data and is not executed.

The pair memory and the arithmetic pipes sit outside the block. The memory returns the pair that sits at `fetch_addr` in the same cycle. The lower pipe reports a branch request and its target for the pair that is being consumed.

Software starts a program with a start pulse, which carries the start address. It grants execution time with a burst request. One burst allows up to `BURST_LEN` pairs while the run bit stays set. If a branch or a stop is still waiting for its delay slot when the budget runs out, one more pair is allowed so that the slot completes.

Top module: `ucode_seq`

## Requirements
- R1: After reset, `fetch_addr` is 0, `status` is 0, and `busy`, `irq`, `burst_busy` and `step` are all 0.
- R2: A `start` pulse loads the wrapped `start_addr` into `fetch_addr`. It sets status bit 8 (run) and `busy`, and it discards any pending branch or stop.
- R3: `step` is high only while run is set and a burst is active. Each step consumes the pair at `fetch_addr` and advances it by 8.
- R4: The sequencer never presents an address at or above the memory size of 16384 bytes. Such an address, whether it comes from a start, a branch or an increment, is masked with 0x3FFF.
- R5: Bit 30 of the upper word requests a stop. Exactly one more pair is then consumed, after which run (status bit 8) and `busy` clear. A stop flag on that delay-slot pair re-arms the stop for one further pair.
- R6: A branch request on a step whose lower word executes takes effect one pair late: the pair after it is consumed, and then `fetch_addr` becomes the target. A new branch request on the delay-slot pair replaces the pending one, and the earlier target is never fetched.
- R7: Bit 31 of the upper word marks the lower word as an immediate. On that step `imm_val` captures the lower word, `lower_exec` stays 0, and a branch request is ignored.
- R8: Bit 28 of the upper word is a debug flag. When `ctrl_irq_en` bit 0 is set, it sets status bit 9 and pulses `irq` for one cycle. Otherwise it has no effect.
- R9: Bit 27 of the upper word is a trap flag. When `ctrl_irq_en` bit 1 is set, it sets status bit 10 and pulses `irq`. Otherwise it has no effect.
- R10: Status bits 9 and 10 stay set until `stat_clr`. A new event in the same cycle as `stat_clr` wins.
- R11: A burst consumes at most 128 pairs. If a branch or stop is pending after the 128th pair, exactly one more is consumed. A burst ends early when run clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| start_addr | input | 16 | Start byte address |
| ctrl_irq_en | input | 2 | Bit 0 enables debug, bit 1 enables trap |
| burst_req | input | 1 | Grants one burst of execution |
| stat_clr | input | 1 | Clears status bits 9 and 10 |
| instr_hi | input | 32 | Upper word of the pair at `fetch_addr` |
| instr_lo | input | 32 | Lower word of the pair at `fetch_addr` |
| br_req | input | 1 | Branch request from the lower pipe for the current pair |
| br_target | input | 16 | Branch target byte address |
| fetch_addr | output | 16 | Byte address of the pair being fetched |
| step | output | 1 | The pair at `fetch_addr` is consumed this cycle |
| lower_exec | output | 1 | The lower word executes on this step |
| imm_val | output | 32 | Last captured immediate |
| status | output | 16 | Bit 8 run, bit 9 debug, bit 10 trap, other bits 0 |
| busy | output | 1 | External busy indication |
| burst_busy | output | 1 | A burst is active |
| irq | output | 1 | Interrupt request pulse |

## Verification
The hardest case to reach is the extra pair at the end of a burst. A branch or a stop has to be pending at the very moment the 128-pair budget runs out. To get there, the bench places a branch, and in a second program a stop flag, exactly on the 128th pair of a straight-line program. It then checks that the delay-slot pair still runs. Delay-slot replacement and stop re-arming are built the same way: flags are placed on adjacent pairs, and the bench compares the full trace of fetched addresses.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  localparam int WORD_W  = 32;
  // upper-word flag bits
  localparam int HI_IMM  = 31;
  localparam int HI_END  = 30;
  localparam int HI_DBG  = 28;
  localparam int HI_TRAP = 27;
  // status bits
  localparam int ST_W    = 16;
  localparam int ST_RUN  = 8;
  localparam int ST_DBG  = 9;
  localparam int ST_TRAP = 10;
  // enable bits
  localparam int EN_DBG  = 0;
  localparam int EN_TRAP = 1;

  typedef struct packed {
    logic imm;
    logic stop;
    logic dbg_ev;
    logic trap_ev;
  } pair_flags_t;
endpackage

// File: rtl/ucseq_decode.sv
module ucseq_decode
  import ucseq_pkg::*;
(
  input  logic [WORD_W-1:0] instr_hi,
  input  logic [1:0]        irq_en,
  input  logic              step,
  output pair_flags_t       flags,
  output logic              lower_ok
);
  always_comb begin
    flags.imm     = instr_hi[HI_IMM];
    flags.stop    = instr_hi[HI_END];
    flags.dbg_ev  = instr_hi[HI_DBG] & irq_en[EN_DBG];
    flags.trap_ev = instr_hi[HI_TRAP] & irq_en[EN_TRAP];
    lower_ok      = step & ~instr_hi[HI_IMM];
  end
endmodule

// File: rtl/ucseq_pc.sv
module ucseq_pc #(
  parameter int AW        = 16,
  parameter int MEM_BYTES = 16384,
  parameter int PAIR_B    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          step,
  input  logic          lower_ok,
  input  logic          br_req,
  input  logic [AW-1:0] br_target,
  output logic [AW-1:0] fetch_addr,
  output logic          br_pend_d
);
  localparam logic [AW-1:0] MASK  = AW'(MEM_BYTES - 1);
  localparam logic [AW-1:0] LIMIT = AW'(MEM_BYTES);
  localparam logic [AW-1:0] INC   = AW'(PAIR_B);

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] a);
    return (a >= LIMIT) ? (a & MASK) : a;
  endfunction

  logic          br_pend;
  logic [AW-1:0] br_tgt;
  logic          br_new;

  assign br_new = lower_ok & br_req;

  always_comb begin
    br_pend_d = br_pend;
    if (start)            br_pend_d = 1'b0;
    else if (step) begin
      if (br_new)         br_pend_d = 1'b1;
      else if (br_pend)   br_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr <= '0;
      br_tgt     <= '0;
      br_pend    <= 1'b0;
    end else begin
      br_pend <= br_pend_d;
      if (start) begin
        fetch_addr <= wrap(start_addr);
      end else if (step) begin
        if (br_new) begin
          br_tgt     <= br_target;
          fetch_addr <= wrap(fetch_addr + INC);
        end else if (br_pend) begin
          fetch_addr <= wrap(br_tgt);
        end else begin
          fetch_addr <= wrap(fetch_addr + INC);
        end
      end
    end
  end

  a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
    start |=> fetch_addr == wrap($past(start_addr)));
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !br_pend) |=> fetch_addr == wrap($past(fetch_addr) + INC));
  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    fetch_addr < LIMIT);
  a_r6_delay_take: assert property (@(posedge clk) disable iff (rst)
    (step && !start && br_pend && !br_new) |=> fetch_addr == wrap($past(br_tgt)));
endmodule

// File: rtl/ucseq_runctl.sv
module ucseq_runctl
  import ucseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              step,
  input  pair_flags_t       flags,
  input  logic              stat_clr,
  input  logic [WORD_W-1:0] instr_lo,
  output logic              run,
  output logic              busy,
  output logic              end_pend_d,
  output logic              st_dbg,
  output logic              st_trap,
  output logic              irq,
  output logic [WORD_W-1:0] imm_val
);
  logic end_pend;
  logic stop_now;

  assign stop_now = step & ~start & end_pend & ~flags.stop;

  always_comb begin
    end_pend_d = end_pend;
    if (start)              end_pend_d = 1'b0;
    else if (step) begin
      if (flags.stop)       end_pend_d = 1'b1;
      else if (end_pend)    end_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      busy     <= 1'b0;
      end_pend <= 1'b0;
      st_dbg   <= 1'b0;
      st_trap  <= 1'b0;
      irq      <= 1'b0;
      imm_val  <= '0;
    end else begin
      end_pend <= end_pend_d;
      if (start) begin
        run  <= 1'b1;
        busy <= 1'b1;
      end else if (stop_now) begin
        run  <= 1'b0;
        busy <= 1'b0;
      end
      if (step && flags.dbg_ev)       st_dbg <= 1'b1;
      else if (stat_clr)              st_dbg <= 1'b0;
      if (step && flags.trap_ev)      st_trap <= 1'b1;
      else if (stat_clr)              st_trap <= 1'b0;
      irq <= step & (flags.dbg_ev | flags.trap_ev);
      if (step && flags.imm)          imm_val <= instr_lo;
    end
  end

  a_r5_stop: assert property (@(posedge clk) disable iff (rst)
    (step && !start && end_pend && !flags.stop) |=> (!run && !busy));
  a_r8_irq_status: assert property (@(posedge clk) disable iff (rst)
    irq |-> (st_dbg || st_trap));
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (st_dbg && !stat_clr) |=> st_dbg);
  a_r7_imm_capture: assert property (@(posedge clk) disable iff (rst)
    (step && flags.imm) |=> imm_val == $past(instr_lo));
endmodule

// File: rtl/ucseq_burst.sv
module ucseq_burst #(
  parameter int BURST_LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic burst_req,
  input  logic run,
  input  logic step,
  input  logic pend_after,
  output logic active
);
  localparam int RW = $clog2(BURST_LEN + 2);
  localparam logic [RW-1:0] LEN = RW'(BURST_LEN);

  logic [RW-1:0] rem;
  logic          extra;
  logic [RW-1:0] used;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      rem    <= '0;
      extra  <= 1'b0;
      used   <= '0;
    end else if (burst_req) begin
      active <= 1'b1;
      rem    <= LEN;
      extra  <= 1'b0;
      used   <= '0;
    end else if (active) begin
      if (!run) begin
        active <= 1'b0;
      end else if (step) begin
        used <= used + 1'b1;
        if (extra) begin
          active <= 1'b0;
        end else if (rem == RW'(1)) begin
          rem <= '0;
          if (pend_after) extra  <= 1'b1;
          else            active <= 1'b0;
        end else begin
          rem <= rem - 1'b1;
        end
      end
    end
  end

  a_r11_budget: assert property (@(posedge clk) disable iff (rst)
    used <= LEN + RW'(1));
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucseq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MEM_BYTES = 16384,
  parameter int BURST_LEN = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [1:0]        ctrl_irq_en,
  input  logic              burst_req,
  input  logic              stat_clr,
  input  logic [WORD_W-1:0] instr_hi,
  input  logic [WORD_W-1:0] instr_lo,
  input  logic              br_req,
  input  logic [AW-1:0]     br_target,
  output logic [AW-1:0]     fetch_addr,
  output logic              step,
  output logic              lower_exec,
  output logic [WORD_W-1:0] imm_val,
  output logic [ST_W-1:0]   status,
  output logic              busy,
  output logic              burst_busy,
  output logic              irq
);
  pair_flags_t flags;
  logic run, br_pend_d, end_pend_d, st_dbg, st_trap;

  assign step = run & burst_busy;

  ucseq_decode u_dec (
    .instr_hi (instr_hi),
    .irq_en   (ctrl_irq_en),
    .step     (step),
    .flags    (flags),
    .lower_ok (lower_exec)
  );

  ucseq_pc #(.AW(AW), .MEM_BYTES(MEM_BYTES), .PAIR_B(8)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (start_addr),
    .step       (step),
    .lower_ok   (lower_exec),
    .br_req     (br_req),
    .br_target  (br_target),
    .fetch_addr (fetch_addr),
    .br_pend_d  (br_pend_d)
  );

  ucseq_runctl u_run (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .step       (step),
    .flags      (flags),
    .stat_clr   (stat_clr),
    .instr_lo   (instr_lo),
    .run        (run),
    .busy       (busy),
    .end_pend_d (end_pend_d),
    .st_dbg     (st_dbg),
    .st_trap    (st_trap),
    .irq        (irq),
    .imm_val    (imm_val)
  );

  ucseq_burst #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .burst_req  (burst_req),
    .run        (run),
    .step       (step),
    .pend_after (br_pend_d | end_pend_d),
    .active     (burst_busy)
  );

  always_comb begin
    status          = '0;
    status[ST_RUN]  = run;
    status[ST_DBG]  = st_dbg;
    status[ST_TRAP] = st_trap;
  end

  a_r7_no_lower: assert property (@(posedge clk) disable iff (rst)
    instr_hi[HI_IMM] |-> !lower_exec);
  a_r3_step_gate: assert property (@(posedge clk) disable iff (rst)
    step |-> (status[ST_RUN] && burst_busy));
endmodule

// File: tb/tb_ucode_seq.sv
`timescale 1ns/1ps
module tb_ucode_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, burst_req = 0, stat_clr = 0;
  logic [15:0] start_addr = '0;
  logic [1:0]  ctrl_irq_en = '0;
  logic [31:0] instr_hi, instr_lo, imm_val;
  logic        br_req, step, lower_exec, busy, burst_busy, irq;
  logic [15:0] br_target, fetch_addr, status;

  always #2.5 clk = ~clk;

  logic [31:0] p_hi [0:2047];
  logic [31:0] p_lo [0:2047];
  logic        b_en [0:2047];
  logic [15:0] b_tg [0:2047];

  always_comb begin
    instr_hi  = p_hi[fetch_addr[13:3]];
    instr_lo  = p_lo[fetch_addr[13:3]];
    br_req    = b_en[fetch_addr[13:3]];
    br_target = b_tg[fetch_addr[13:3]];
  end

  ucode_seq dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .ctrl_irq_en(ctrl_irq_en), .burst_req(burst_req), .stat_clr(stat_clr),
    .instr_hi(instr_hi), .instr_lo(instr_lo), .br_req(br_req), .br_target(br_target),
    .fetch_addr(fetch_addr), .step(step), .lower_exec(lower_exec), .imm_val(imm_val),
    .status(status), .busy(busy), .burst_busy(burst_busy), .irq(irq)
  );

  int checks = 0, fails = 0;
  int tcount = 0, irqn = 0;
  logic [15:0] trace [0:299];
  logic        lex   [0:299];

  always @(negedge clk) begin
    if (!rst && step && tcount < 300) begin
      trace[tcount] = fetch_addr;
      lex[tcount]   = lower_exec;
      tcount++;
    end
    if (!rst && irq) irqn++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 2048; i++) begin
      p_hi[i] = '0; p_lo[i] = '0; b_en[i] = 1'b0; b_tg[i] = '0;
    end
  endtask

  function automatic int ix(input logic [15:0] a);
    return int'(a[13:3]);
  endfunction

  task automatic launch(input logic [15:0] a, input bit with_burst);
    @(negedge clk);
    tcount = 0; irqn = 0;
    start = 1; start_addr = a; burst_req = with_burst;
    @(negedge clk);
    start = 0; burst_req = 0;
    if (with_burst)
      for (int i = 0; i < 400 && burst_busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R1 fetch_addr", fetch_addr, 0);
    chk_eq("R1 status", status, 0);
    chk_eq("R1 busy/irq/burst/step", {busy, irq, burst_busy, step}, 0);
  endtask

  task automatic t_linear();
    clear_prog();
    launch(16'h0100, 1);
    chk_eq("R11 pairs per burst", tcount, 128);
    chk_eq("R3 first addr", trace[0], 16'h0100);
    chk_eq("R3 addr stride", trace[57], 16'h0100 + 57 * 8);
    chk_eq("R3 last addr", trace[127], 16'h0100 + 127 * 8);
    chk_eq("R2 run stays set", status[8], 1);
    chk_eq("R11 burst ended", burst_busy, 0);
  endtask

  task automatic t_wrap();
    clear_prog();
    p_hi[0] = 32'h4000_0000;
    launch(16'h3FF0, 1);
    chk_eq("R4 trace len", tcount, 4);
    chk_eq("R4 wrap to 0", trace[2], 16'h0000);
    chk_eq("R5 slot addr", trace[3], 16'h0008);
    chk_eq("R5 run cleared", status[8], 0);
    chk_eq("R5 busy cleared", busy, 0);
    launch(16'h5010, 0);
    chk_eq("R4 start masked", fetch_addr, 16'h1010);
    chk_eq("R2 run set", status[8], 1);
    chk_eq("R2 busy set", busy, 1);
    chk_eq("R3 no step without burst", step, 0);
  endtask

  task automatic t_end_rearm();
    clear_prog();
    p_hi[ix(16'h0500)] = 32'h4000_0000;
    p_hi[ix(16'h0508)] = 32'h4000_0000;
    launch(16'h0500, 1);
    chk_eq("R5 rearm length", tcount, 3);
    chk_eq("R5 rearm last", trace[2], 16'h0510);
    chk_eq("R11 early end", burst_busy, 0);
  endtask

  task automatic t_branch();
    clear_prog();
    b_en[ix(16'h0200)] = 1; b_tg[ix(16'h0200)] = 16'h0400;
    p_hi[ix(16'h0400)] = 32'h4000_0000;
    launch(16'h0200, 1);
    chk_eq("R6 length", tcount, 4);
    chk_eq("R6 slot", trace[1], 16'h0208);
    chk_eq("R6 target", trace[2], 16'h0400);
    clear_prog();
    b_en[ix(16'h0600)] = 1; b_tg[ix(16'h0600)] = 16'h0800;
    b_en[ix(16'h0608)] = 1; b_tg[ix(16'h0608)] = 16'h0A00;
    p_hi[ix(16'h0A00)] = 32'h4000_0000;
    launch(16'h0600, 1);
    chk_eq("R6 replace length", tcount, 5);
    chk_eq("R6 replace slot", trace[2], 16'h0610);
    chk_eq("R6 replace target", trace[3], 16'h0A00);
  endtask

  task automatic t_imm();
    clear_prog();
    p_hi[ix(16'h0C00)] = 32'h8000_0000;
    p_lo[ix(16'h0C00)] = 32'hDEAD_BEEF;
    b_en[ix(16'h0C00)] = 1; b_tg[ix(16'h0C00)] = 16'h0E00;
    p_hi[ix(16'h0C08)] = 32'h4000_0000;
    launch(16'h0C00, 1);
    chk_eq("R7 lower not executed", lex[0], 0);
    chk_eq("R7 next lower executes", lex[1], 1);
    chk_eq("R7 immediate captured", imm_val, 32'hDEAD_BEEF);
    chk_eq("R7 branch ignored", trace[2], 16'h0C10);
  endtask

  task automatic t_irq();
    clear_prog();
    p_hi[ix(16'h1000)] = 32'h5800_0000;
    ctrl_irq_en = 2'b00;
    launch(16'h1000, 1);
    chk_eq("R8 disabled no irq", irqn, 0);
    chk_eq("R9 disabled no status", status[10:9], 0);
    ctrl_irq_en = 2'b01;
    clear_prog();
    p_hi[ix(16'h1100)] = 32'h4800_0000;
    launch(16'h1100, 1);
    chk_eq("R9 trap gated off", status[10], 0);
    chk_eq("R8 debug off no irq", irqn, 0);
    clear_prog();
    p_hi[ix(16'h1100)] = 32'h5000_0000;
    launch(16'h1100, 1);
    chk_eq("R8 single irq pulse", irqn, 1);
    chk_eq("R8 debug status", status[10:9], 2'b01);
    ctrl_irq_en = 2'b10;
    clear_prog();
    p_hi[ix(16'h1200)] = 32'h4800_0000;
    launch(16'h1200, 1);
    chk_eq("R9 trap irq", irqn, 1);
    chk_eq("R10 both sticky", status[10:9], 2'b11);
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0;
    chk_eq("R10 cleared", status[10:9], 2'b00);
    ctrl_irq_en = 2'b00;
  endtask

  task automatic t_burst_extra();
    clear_prog();
    b_en[ix(16'h23F8)] = 1; b_tg[ix(16'h23F8)] = 16'h3000;
    launch(16'h2000, 1);
    chk_eq("R11 extra for branch", tcount, 129);
    chk_eq("R11 extra addr", trace[128], 16'h2400);
    chk_eq("R6 target after burst", fetch_addr, 16'h3000);
    clear_prog();
    p_hi[ix(16'h1BF8)] = 32'h4000_0000;
    launch(16'h1800, 1);
    chk_eq("R11 extra for stop", tcount, 129);
    chk_eq("R5 stopped after extra", status[8], 0);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_prog();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_linear();
    t_wrap();
    t_end_rearm();
    t_branch();
    t_imm();
    t_irq();
    t_burst_extra();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule